// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a supervision timer. Host software has to restart it regularly with a two-write key sequence. A two-bit mode field arms the timer. While the field holds the watchdog code, a prescaler divides an external timebase tick, and the divided steps advance a timeout counter. If the counter reaches its limit before the host restarts it, the block raises a sticky overflow flag. On the same clock edge it starts a reset pulse of fixed length for the surrounding reset logic.

A restart takes two ordered writes to the key bits. The first write sets key A and clears key B. A later write clears key A and sets key B. A single write does not restart the timer. Neither does a repeated first step, nor a second step that arrives on its own. Any key write that does not advance the sequence puts the tracker back to idle. After an expiry the counter reloads from zero and keeps running for as long as the mode field keeps the watchdog code. The timeout length is set by parameters: ticks per step times steps per timeout. A simulation can therefore use a short period, and silicon can set the full period.

Top module: `kwdt_top`

## Requirements
- R1: After reset, ovf_flag and rst_pulse are 0, the mode field is 00 and the key tracker is idle.
- R2: Mode codes 00, 01 and 10 hold the prescaler and counter at zero, so no expiry occurs. Writing code 11 starts counting from zero on the edge after the write. Leaving code 11 clears the count, so re-arming starts a full period again.
- R3: With code 11 held, every PSC_DIV ticks (tick_in high at a clock edge) make one step. The timer expires on the TMO_STEPS-th step. ovf_flag goes high on the edge of the PSC_DIV*TMO_STEPS-th tick after arming or restart.
- R4: A key write with {key_a,key_b}=2'b10, followed by a key write with 2'b01 and no other key write between them, restarts the timer. The restart clears the prescaler and the counter on the edge of the second write, and cycles without key writes may separate the two writes.
- R5: A key write that does not advance the sequence returns the tracker to idle without a restart. This covers a 2'b01 write from idle, a repeated 2'b10, and a 2'b00 or 2'b11 write.
- R6: ovf_flag is set on expiry and stays set until a cycle with ovf_clr high and no expiry. When expiry and ovf_clr fall in the same cycle, the flag is set.
- R7: rst_pulse rises on the same edge as the expiry sets ovf_flag. It stays high for PULSE_LEN cycles, and a new expiry restarts the full length.
- R8: After an expiry with code 11 kept, the counter reloads and expires again PSC_DIV*TMO_STEPS ticks later.
- R9: If the second key write falls in the cycle in which the timer would expire, the restart wins. No flag is set and no pulse is produced.
- R10: Key writes are ignored while the mode code is not 11, and the tracker stays idle. A 2'b10 written before arming does not make a later 2'b01 a valid second step.
- R11: Cycles with tick_in low do not advance the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode value; 2'b11 arms the watchdog |
| key_we | input | 1 | Write strobe for the key bits |
| key_a | input | 1 | Key bit A of the key write |
| key_b | input | 1 | Key bit B of the key write |
| tick_in | input | 1 | Timebase tick, one cycle wide per tick |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky watchdog overflow status |
| rst_pulse | output | 1 | Reset pulse, PULSE_LEN cycles per expiry |

## Verification
Two events can fall in the same cycle: completing the service sequence and the timer expiring. The bench sweeps the cycle of the key writes across the whole period after arming. The last offset puts the second write exactly on the expiry edge. For that case it expects neither the flag nor the pulse, and it expects the next expiry one full period after that edge. A second collision holds ovf_clr high through an expiry and expects the flag to end up set.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } kseq_e;

  localparam logic [1:0] MODE_WDOG  = 2'b11;
  // key patterns as {key_a, key_b}
  localparam logic [1:0] KEY_FIRST  = 2'b10;
  localparam logic [1:0] KEY_SECOND = 2'b01;

  function automatic int unsigned width_of(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       key_we,
  input  logic [1:0] key_pat,
  output logic       restart
);

  kseq_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
    end else if (!active) begin
      state_q <= KS_IDLE;
    end else if (key_we) begin
      case (state_q)
        KS_IDLE:  state_q <= (key_pat == KEY_FIRST) ? KS_ARMED : KS_IDLE;
        default:  state_q <= KS_IDLE;
      endcase
    end
  end

  assign restart = active && key_we && (state_q == KS_ARMED) && (key_pat == KEY_SECOND);

endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
  import kwdt_pkg::*;
#(
  parameter int unsigned DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic step
);

  localparam int unsigned PW = width_of(DIV);

  generate
    if (DIV <= 1) begin : g_bypass
      assign step = tick && !clear;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (clear) begin
          cnt_q <= '0;
        end else if (tick) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end

      assign step = tick && !clear && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned STEPS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic expire,
  output logic at_zero
);

  localparam int unsigned CW = width_of(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign expire  = step && !clear && (cnt_q == LAST);
  assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse
  import kwdt_pkg::*;
#(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);

  localparam int unsigned LW = width_of(LEN + 1);
  localparam logic [LW-1:0] LOAD = LW'(LEN);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire) begin
      left_q <= LOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign pulse_o = (left_q != '0);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned PSC_DIV   = 1000,
  parameter int unsigned TMO_STEPS = 128,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_wdata,
  input  logic       key_we,
  input  logic       key_a,
  input  logic       key_b,
  input  logic       tick_in,
  input  logic       ovf_clr,
  output logic       ovf_flag,
  output logic       rst_pulse
);

  logic [1:0] mode_q;
  logic       active;
  logic       restart;
  logic       clear;
  logic       step;
  logic       expire;
  logic       cnt_zero;
  logic       ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
    end else if (mode_we) begin
      mode_q <= mode_wdata;
    end
  end

  assign active = (mode_q == MODE_WDOG);
  assign clear  = restart || !active;

  kwdt_keyseq u_keyseq (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .key_we  (key_we),
    .key_pat ({key_a, key_b}),
    .restart (restart)
  );

  kwdt_prescaler #(.DIV(PSC_DIV)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .tick  (tick_in),
    .step  (step)
  );

  kwdt_counter #(.STEPS(TMO_STEPS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .step    (step),
    .expire  (expire),
    .at_zero (cnt_zero)
  );

  kwdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (expire),
    .pulse_o (rst_pulse)
  );

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (expire) begin
      ovf_q <= 1'b1;
    end else if (ovf_clr) begin
      ovf_q <= 1'b0;
    end
  end

  assign ovf_flag = ovf_q;

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int unsigned PULSE_LEN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic ovf_clr,
  input logic ovf_flag,
  input logic rst_pulse,
  input logic active,
  input logic restart,
  input logic expire,
  input logic cnt_zero
);

  logic [15:0] age_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      seen_q <= 1'b0;
    end else if (expire) begin
      age_q  <= '0;
      seen_q <= 1'b1;
    end else if (age_q != 16'hFFFF) begin
      age_q <= age_q + 1'b1;
    end
  end

  p_no_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !rst_pulse);

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (rst_pulse == (32'(age_q) < PULSE_LEN)));

  p_pulse_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> ovf_flag);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt_zero);

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_zero);

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ovf_flag);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !expire) |=> !ovf_flag);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !expire);

endmodule

bind kwdt_top kwdt_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ovf_clr   (ovf_clr),
  .ovf_flag  (ovf_flag),
  .rst_pulse (rst_pulse),
  .active    (active),
  .restart   (restart),
  .expire    (expire),
  .cnt_zero  (cnt_zero)
);

// File: tb/tb_kwdt_top.sv
`timescale 1ns/1ps
module tb_kwdt_top;

  localparam int DIV  = 3;
  localparam int TMO  = 4;
  localparam int PLEN = 4;
  localparam int T    = DIV * TMO;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic       key_we = 1'b0;
  logic       key_a = 1'b0;
  logic       key_b = 1'b0;
  logic       tick_in = 1'b1;
  logic       ovf_clr = 1'b0;
  logic       ovf_flag;
  logic       rst_pulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  kwdt_top #(.PSC_DIV(DIV), .TMO_STEPS(TMO), .PULSE_LEN(PLEN)) dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .key_we(key_we), .key_a(key_a), .key_b(key_b), .tick_in(tick_in),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .rst_pulse(rst_pulse)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_mode(input logic [1:0] m);
    mode_we = 1'b1; mode_wdata = m; cyc(1); mode_we = 1'b0;
  endtask

  task automatic wr_key(input logic [1:0] p);
    key_we = 1'b1; {key_a, key_b} = p; cyc(1); key_we = 1'b0;
  endtask

  task automatic fresh();
    wr_mode(2'b00);
    ovf_clr = 1'b1; cyc(PLEN + 2); ovf_clr = 1'b0; cyc(1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 flag", ovf_flag, 1'b0);
    chk("R1 pulse", rst_pulse, 1'b0);
    rst_n = 1'b1;
    cyc(1);

    // R3 / R7 / R8 / R6 basic expiry chain
    fresh(); wr_mode(2'b11);
    cyc(T - 1);
    chk("R3 no early flag", ovf_flag, 1'b0);
    chk("R7 no early pulse", rst_pulse, 1'b0);
    cyc(1);
    chk("R3 flag at timeout", ovf_flag, 1'b1);
    chk("R7 pulse with flag", rst_pulse, 1'b1);
    cyc(PLEN - 1);
    chk("R7 pulse last cycle", rst_pulse, 1'b1);
    cyc(1);
    chk("R7 pulse ended", rst_pulse, 1'b0);
    chk("R6 flag sticky", ovf_flag, 1'b1);
    ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
    chk("R6 flag cleared", ovf_flag, 1'b0);
    cyc(T - PLEN - 2);
    chk("R8 no early reload expiry", ovf_flag, 1'b0);
    cyc(1);
    chk("R8 reload expiry", ovf_flag, 1'b1);
    ovf_clr = 1'b1;
    cyc(T - 1);
    chk("R6 cleared while held", ovf_flag, 1'b0);
    cyc(1);
    chk("R6 set beats clear", ovf_flag, 1'b1);
    chk("R7 pulse on third expiry", rst_pulse, 1'b1);
    ovf_clr = 1'b0;

    // R11 tick gating
    fresh(); tick_in = 1'b0; wr_mode(2'b11);
    cyc(3 * T);
    chk("R11 no ticks no expiry", ovf_flag, 1'b0);
    tick_in = 1'b1;
    cyc(T - 1);
    chk("R11 resumes", ovf_flag, 1'b0);
    cyc(1);
    chk("R11 expiry after T ticks", ovf_flag, 1'b1);

    // R2 non-watchdog codes
    for (int m = 0; m < 3; m++) begin
      fresh(); wr_mode(2'(m));
      cyc(3 * T);
      chk("R2 code stopped", ovf_flag, 1'b0);
      chk("R2 code no pulse", rst_pulse, 1'b0);
    end
    fresh(); wr_mode(2'b11); cyc(T - 2); wr_mode(2'b00); wr_mode(2'b11);
    cyc(T - 1);
    chk("R2 rearm restarts count", ovf_flag, 1'b0);
    cyc(1);
    chk("R2 rearm expiry", ovf_flag, 1'b1);

    // R10 key writes while disarmed
    fresh(); wr_key(2'b10); wr_mode(2'b11); wr_key(2'b01);
    cyc(T - 2);
    chk("R10 early", ovf_flag, 1'b0);
    cyc(1);
    chk("R10 no restart", ovf_flag, 1'b1);

    // R4 / R9 service offset sweep
    for (int d = 0; d <= T - 2; d++) begin
      fresh(); wr_mode(2'b11); cyc(d);
      wr_key(2'b10); wr_key(2'b01);
      if (d == T - 2) begin
        chk("R9 collision no flag", ovf_flag, 1'b0);
        chk("R9 collision no pulse", rst_pulse, 1'b0);
      end
      cyc(T - 1);
      chk("R4 serviced no flag", ovf_flag, 1'b0);
      cyc(1);
      chk("R4 expiry after restart", ovf_flag, 1'b1);
    end

    // R4 with idle gap between the two writes
    fresh(); wr_mode(2'b11); wr_key(2'b10); cyc(2); wr_key(2'b01);
    cyc(T - 1);
    chk("R4 gap serviced", ovf_flag, 1'b0);
    cyc(1);
    chk("R4 gap expiry", ovf_flag, 1'b1);

    // R5 all pattern pairs
    for (int p = 0; p < 16; p++) begin
      logic [1:0] p1, p2;
      logic good;
      p1 = 2'(p >> 2); p2 = 2'(p);
      good = (p1 == 2'b10) && (p2 == 2'b01);
      fresh(); wr_mode(2'b11); wr_key(p1); wr_key(p2);
      cyc(T - 3);
      chk("R5 pair early", ovf_flag, 1'b0);
      cyc(1);
      chk("R5 pair restart decision", ovf_flag, !good);
    end

    // R5 repeated first step then second
    fresh(); wr_mode(2'b11); wr_key(2'b10); wr_key(2'b10); wr_key(2'b01);
    cyc(T - 4);
    chk("R5 repeat early", ovf_flag, 1'b0);
    cyc(1);
    chk("R5 repeated first breaks", ovf_flag, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule